// File: doc/BRIEF.md
# Three-Group Interrupt Flag Controller

This block collects seventeen single-cycle interrupt source pulses into three fixed priority groups (high, middle, low). Each source owns one pending flag and one enable bit. A flag is latched by its source pulse, and software clears it by writing 1 to its bit. Each group drives one request line, raised while any flag in that group is both pending and enabled. A read-only summary byte reports the same three group states.

Software reaches the block through a small register port: a write strobe, a 3-bit register offset and a byte of write data. The read data follows the offset combinationally. Sources 0..4 form the high group, sources 5..10 the middle group and sources 11..16 the low group. Inside a group, the source with the lowest number sits in flag bit 0. There is no sequencing state in this block. Every register is a flag or enable bit that updates on each clock edge.

Top module: `irqc_top`

## Requirements
- R1: Register map: offset 0/1/2 hold the high/middle/low flag bytes, offset 3/4/5 the matching enable bytes, and offset 6 the summary (bit 2 high, bit 1 middle, bit 0 low). Group source k appears in bit k. Bits above a group's size and offset 7 read 0.
- R2: A pulse on `src_pulse[i]` sets flag i at the next clock edge, whether or not source i is enabled. No flag becomes set without a pulse.
- R3: A write to a flag byte clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R4: When a source pulse and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R5: A write to an enable byte loads the group's enable bits from the low data bits. Enable bits change only on such a write.
- R6: `irq_req[2]`, `irq_req[1]` and `irq_req[0]` are the OR over the high, middle and low groups of flag AND enable. They follow the registered flags without delay and equal the summary byte.
- R7: After reset, all flags and enables are 0 and all request lines are low.
- R8: Writes to offset 6 or offset 7 change no flag and no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_pulse | input | 17 | One-cycle source pulses, bit i = source i |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| irq_req | output | 3 | Group requests: bit 2 high, 1 middle, 0 low |

## Verification
The bench pulses every source with all enables off. A design that gated flag capture by the enable would read back zero, and a design that leaked disabled flags to the request lines would raise a line. It clears each flag one bit at a time and checks the neighbouring bits, which catches a clear that wipes the whole byte. It applies a pulse and a clear to the same flag in one cycle, where a clear-wins design loses the flag. It sweeps all 256 enable values for each group with every flag set, which exposes a wrong group-to-line mapping, upper bits that are stored, and writes to the summary offset or offset 7 that leak into state.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int DW     = 8;
    localparam int AW     = 3;
    localparam int NGRP   = 3;
    localparam int SRC_N  = 17;

    // group 0 = high, 1 = middle, 2 = low
    function automatic int grp_n(input int g);
        return (g == 0) ? 5 : 6;
    endfunction

    function automatic int grp_base(input int g);
        int b;
        b = 0;
        for (int k = 0; k < g; k++) b += grp_n(k);
        return b;
    endfunction
endpackage

// File: rtl/irqc_bank.sv
module irqc_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pulse,
    input  logic         flag_wr,
    input  logic         en_wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] flag,
    output logic [N-1:0] en,
    output logic         active
);
    logic [N-1:0] clr_mask;
    logic [N-1:0] flag_nxt;

    always_comb begin
        clr_mask = flag_wr ? wdata : '0;
        // a new pulse wins over a clear in the same cycle
        flag_nxt = (flag & ~clr_mask) | pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= '0;
            en   <= '0;
        end else begin
            flag <= flag_nxt;
            if (en_wr) en <= wdata;
        end
    end

    assign active = |(flag & en);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] src_pulse,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic [NGRP-1:0]  irq_req
);
    localparam logic [AW-1:0] SUM_ADDR = AW'(2 * NGRP);

    logic [DW-1:0]    flag_byte [NGRP];
    logic [DW-1:0]    en_byte   [NGRP];
    logic [NGRP-1:0]  grp_act;
    logic [SRC_N-1:0] flag_all;
    logic [SRC_N-1:0] en_all;

    for (genvar g = 0; g < NGRP; g++) begin : g_bank
        localparam int N    = grp_n(g);
        localparam int BASE = grp_base(g);
        logic [N-1:0] f;
        logic [N-1:0] e;

        irqc_bank #(.N(N)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .pulse   (src_pulse[BASE +: N]),
            .flag_wr (reg_wr && (reg_addr == AW'(g))),
            .en_wr   (reg_wr && (reg_addr == AW'(NGRP + g))),
            .wdata   (reg_wdata[N-1:0]),
            .flag    (f),
            .en      (e),
            .active  (grp_act[g])
        );

        assign flag_byte[g]        = {{(DW-N){1'b0}}, f};
        assign en_byte[g]          = {{(DW-N){1'b0}}, e};
        assign flag_all[BASE +: N] = f;
        assign en_all[BASE +: N]   = e;
        // high group on the top request bit
        assign irq_req[NGRP-1-g]   = grp_act[g];
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr < AW'(NGRP))
            reg_rdata = flag_byte[reg_addr];
        else if (reg_addr < SUM_ADDR)
            reg_rdata = en_byte[reg_addr - AW'(NGRP)];
        else if (reg_addr == SUM_ADDR)
            reg_rdata = {{(DW-NGRP){1'b0}}, irq_req};
    end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [16:0] src_pulse,
    input logic        reg_wr,
    input logic [2:0]  reg_addr,
    input logic [7:0]  reg_wdata,
    input logic [2:0]  irq_req,
    input logic [16:0] flag_all,
    input logic [16:0] en_all
);
    // R2
    pulse_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_pulse) |=> ((flag_all & $past(src_pulse)) == $past(src_pulse)));

    // R2
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((flag_all & ~$past(flag_all) & ~$past(src_pulse)) == 17'd0));

    // R3
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0 && reg_wdata[0] && !src_pulse[0]) |=> !flag_all[0]);

    // R4
    pulse_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd1 && reg_wdata[0] && src_pulse[5]) |=> flag_all[5]);

    // R5
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr >= 3'd3 && reg_addr <= 3'd5) |=> $stable(en_all));

    // R6
    no_en_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_all == 17'd0) |-> (irq_req == 3'd0));
endmodule

bind irqc_top irqc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_pulse (src_pulse),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq_req   (irq_req),
    .flag_all  (flag_all),
    .en_all    (en_all)
);

// File: tb/irqc_top_test.sv
module irqc_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] src_pulse = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [2:0]  irq_req;

    int checks = 0;
    int failures = 0;
    logic [16:0] mflag = '0;
    logic [16:0] men = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqc_top uut (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req)
    );

    function automatic int gsize(input int g);
        return (g == 0) ? 5 : 6;
    endfunction
    function automatic int gbase(input int g);
        return (g == 0) ? 0 : ((g == 1) ? 5 : 11);
    endfunction

    function automatic logic [7:0] pack(input logic [16:0] v, input int g);
        logic [7:0] r = '0;
        for (int j = 0; j < gsize(g); j++) r[j] = v[gbase(g) + j];
        return r;
    endfunction

    function automatic logic [2:0] exp_irq();
        logic [2:0] r;
        for (int g = 0; g < 3; g++) r[2-g] = |(pack(mflag, g) & pack(men, g));
        return r;
    endfunction

    function automatic logic [7:0] exp_reg(input int a);
        if (a < 3) return pack(mflag, a);
        if (a < 6) return pack(men, a - 3);
        if (a == 6) return {5'd0, exp_irq()};
        return 8'd0;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // one clock of stimulus, bench model updated from the requirements
    task automatic step(input logic [16:0] p, input logic wr, input int a, input logic [7:0] d);
        @(negedge clk);
        src_pulse = p; reg_wr = wr; reg_addr = 3'(a); reg_wdata = d;
        @(posedge clk);
        #1;
        src_pulse = '0; reg_wr = 1'b0;
        if (wr && a < 3)
            for (int j = 0; j < gsize(a); j++)
                if (d[j]) mflag[gbase(a) + j] = 1'b0;
        if (wr && a >= 3 && a < 6)
            for (int j = 0; j < gsize(a - 3); j++)
                men[gbase(a - 3) + j] = d[j];
        mflag = mflag | p;
    endtask

    task automatic read_chk(input string tag, input int a);
        @(negedge clk);
        reg_addr = 3'(a);
        #1;
        check(tag, reg_rdata, exp_reg(a));
        check({tag, " irq R6"}, irq_req, exp_irq());
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a < 8; a++) read_chk(tag, a);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R7 reset state
        read_all("R7 reset");
        check("R7 irq after reset", irq_req, 3'd0);

        // R2 / R1: every source latches with enables off; no request
        for (int i = 0; i < 17; i++) begin
            step(17'(1) << i, 1'b0, 0, 8'd0);
            read_chk("R2 flag set while disabled", i < 5 ? 0 : (i < 11 ? 1 : 2));
            check("R2 no irq while disabled", irq_req, 3'd0);
        end
        read_all("R1 map all flags");

        // R8: writes to summary and offset 7 do nothing
        step('0, 1'b1, 6, 8'hFF);
        step('0, 1'b1, 7, 8'hFF);
        read_all("R8 ignored writes");

        // R5 / R6: sweep all enable values per group with all flags set
        for (int g = 0; g < 3; g++) begin
            for (int v = 0; v < 256; v++) begin
                step('0, 1'b1, 3 + g, 8'(v));
                read_chk("R5 enable readback", 3 + g);
            end
            read_chk("R6 summary", 6);
            step('0, 1'b1, 3 + g, 8'd0);
        end

        // R3: clear one bit at a time with all enabled
        for (int g = 0; g < 3; g++) step('0, 1'b1, 3 + g, 8'hFF);
        for (int g = 0; g < 3; g++) begin
            step('0, 1'b1, g, 8'd0);
            read_chk("R3 zero write keeps flags", g);
            for (int j = 0; j < gsize(g); j++) begin
                step('0, 1'b1, g, 8'(1) << j);
                read_chk("R3 single-bit clear", g);
                read_chk("R6 summary during clears", 6);
            end
        end
        read_all("R3 all cleared");

        // R4: pulse and clear of the same flag in one cycle
        for (int i = 0; i < 17; i++) begin
            int g;
            g = i < 5 ? 0 : (i < 11 ? 1 : 2);
            step(17'(1) << i, 1'b1, g, 8'hFF);
            read_chk("R4 pulse beats clear", g);
            step('0, 1'b1, g, 8'hFF);
            read_chk("R3 clear after R4", g);
        end

        // R6 mixed pattern across groups
        step(17'h0A5A5, 1'b0, 0, 8'd0);
        step('0, 1'b1, 3, 8'h02);
        step('0, 1'b1, 4, 8'h01);
        step('0, 1'b1, 5, 8'h00);
        read_all("R6 mixed pattern");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule